// File: doc/BRIEF.md
# Glitch-free power-of-two system clock divider

This block takes the fast master clock and divides it by 2^N to make the single system clock for the processor and every synchronous peripheral. N is a 4-bit code written through a simple write strobe at run time. A strap input chosen during reset sets the starting ratio to 8 or to 1. A busy output stays high from an accepted write until the new ratio has been taken up.

An up-counter runs on the undivided clock. Each of its bits is a candidate divided clock, and the undivided clock itself is the divide-by-1 candidate. A new selection waits until the counter wraps to all zeros. At that point every candidate is low and phase-aligned, and the output multiplexer changes over during the low half of the input clock. Because the wait depends on where the counter happens to be, the latency of a change varies from one write to the next.

Top module: `sysclk_prescaler`

## Requirements
- R1: While reset is asserted and afterwards until the first accepted write, the ratio is 8 (code 3) when `defDiv8` is 1 and 1 (code 0) when it is 0; `busy` is 0 during reset.
- R2: With code c in 0..8 in effect, each high phase and each low phase of `clkOut` lasts 2^c half-periods of `clkIn` (code 0 makes `clkOut` follow `clkIn`).
- R3: A write with a code of 9..15 is ignored: `busy` does not rise, the ratio in effect is unchanged and any pending code is kept.
- R4: A write with a code of 0..8 makes `busy` read 1 from the `clkIn` rising edge that samples the write.
- R5: A valid write that arrives while `busy` is 1 replaces the pending code; only the last such code is applied.
- R6: A pending code is taken up only when the internal 8-bit counter wraps to zero: `busy` falls on that rising edge, which comes at most 256 input cycles after the write, and the output multiplexer switches on the next falling edge of `clkIn`.
- R7: Across a ratio change, no high or low phase of `clkOut` is shorter than the shorter of the old and new half-periods, so no runt pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Undivided master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| defDiv8 | input | 1 | Reset strap: 1 starts at divide-by-8, 0 at divide-by-1 |
| wrEn | input | 1 | Write strobe for a new division code, sampled on the rising edge of clkIn |
| wrCode | input | 4 | Division code; ratio is 2^code for 0..8 |
| clkOut | output | 1 | Divided system clock |
| busy | output | 1 | High while a ratio change is pending |

## Verification
The bench times every edge of the output clock and steps through all 81 ordered pairs of legal codes. That includes the moves to and from divide-by-1, where the output goes from a counter bit to the raw input clock. A design that switched the multiplexer at the write, or at any point other than the aligned wrap, would produce a phase shorter than both half-periods. A design that never took up the code would keep the old phase length after busy fell. Reserved codes are written both while idle and while a change is pending: a design that decoded them would raise busy or land on the wrong ratio. Overwriting a pending code exposes a design that applies the first write instead of the last.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;

  // Width of the division code carried by the write port.
  localparam int CODE_W = 4;

  // Strobes from the control side to the counter/mux datapath.
  typedef struct packed {
    logic              arm;   // take up the pending code at this wrap
    logic [CODE_W-1:0] code;  // code to take up
  } armStrobe_t;

endpackage

// File: rtl/prescaler_ctrl.sv
module prescaler_ctrl
  import prescaler_pkg::*;
#(
  parameter int MAX_CODE = 8
) (
  input  logic              clkIn,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CODE_W-1:0] wrCode,
  input  logic              wrapNext,
  output armStrobe_t        strobe,
  output logic              busy
);

  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(MAX_CODE);

  logic              codeValid;
  logic              takeWrite;
  logic [CODE_W-1:0] pendCode;

  assign codeValid = (wrCode <= TOP_CODE);
  assign takeWrite = wrEn && codeValid;

  // A fresh write always wins over arming, so a write landing on the wrap
  // edge keeps the block busy until the following wrap.
  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      pendCode <= '0;
      busy     <= 1'b0;
    end else if (takeWrite) begin
      pendCode <= wrCode;
      busy     <= 1'b1;
    end else if (busy && wrapNext) begin
      busy     <= 1'b0;
    end
  end

  always_comb begin
    strobe.arm  = busy && wrapNext && !takeWrite;
    strobe.code = pendCode;
  end

  // R4
  wr_sets_busy_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    (wrEn && (wrCode <= TOP_CODE)) |=> busy);

  // R3
  reserved_ignored_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    (wrEn && (wrCode > TOP_CODE) && !busy) |=> !busy);

  // R6
  busy_clear_at_wrap_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    $fell(busy) |-> $past(wrapNext));

endmodule

// File: rtl/prescaler_dp.sv
module prescaler_dp
  import prescaler_pkg::*;
#(
  parameter int MAX_CODE = 8,
  parameter int DEF_CODE = 3
) (
  input  logic       clkIn,
  input  logic       rstN,
  input  logic       defDiv8,
  input  armStrobe_t strobe,
  output logic       wrapNext,
  output logic       clkOut
);

  localparam int CNT_W = MAX_CODE;
  localparam logic [CODE_W-1:0] RST_DEF = CODE_W'(DEF_CODE);

  logic [CNT_W-1:0]    cnt;
  logic [CODE_W-1:0]   armCode;
  logic [CODE_W-1:0]   selCode;
  logic [MAX_CODE:0]   taps;
  logic [CODE_W-1:0]   rstCode;

  assign rstCode  = defDiv8 ? RST_DEF : '0;
  assign wrapNext = &cnt;

  // Free-running counter on the undivided clock; bit k-1 is the
  // divide-by-2^k candidate and all bits fall together at the wrap.
  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cnt + 1'b1;
  end

  // Code latched on the wrap edge, when every counter tap falls.
  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN)           armCode <= rstCode;
    else if (strobe.arm) armCode <= strobe.code;
  end

  // Multiplexer select moves on the falling input edge while the counter
  // reads zero: the input clock and every tap are low at that instant.
  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN)            selCode <= rstCode;
    else if (cnt == '0)   selCode <= armCode;
  end

  assign taps[0] = clkIn;
  generate
    for (genvar i = 1; i <= MAX_CODE; i++) begin : g_tap
      assign taps[i] = cnt[i-1];
    end
  endgenerate

  always_comb begin
    clkOut = 1'b0;
    for (int i = 0; i <= MAX_CODE; i++) begin
      if (selCode == CODE_W'(i)) clkOut = taps[i];
    end
  end

  // R6
  arm_only_at_wrap_chk: assert property (@(posedge clkIn) disable iff (!rstN)
    (armCode != $past(armCode)) |-> $past(wrapNext));

  // R7
  switch_at_zero_chk: assert property (@(negedge clkIn) disable iff (!rstN)
    (selCode != $past(selCode)) |-> ($past(cnt) == '0));

endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler
  import prescaler_pkg::*;
#(
  parameter int MAX_CODE = 8,
  parameter int DEF_CODE = 3
) (
  input  logic        clkIn,
  input  logic        rstN,
  input  logic        defDiv8,
  input  logic        wrEn,
  input  logic [3:0]  wrCode,
  output logic        clkOut,
  output logic        busy
);

  armStrobe_t strobe;
  logic       wrapNext;

  prescaler_ctrl #(.MAX_CODE(MAX_CODE)) u_ctrl (
    .clkIn   (clkIn),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrCode  (wrCode),
    .wrapNext(wrapNext),
    .strobe  (strobe),
    .busy    (busy)
  );

  prescaler_dp #(.MAX_CODE(MAX_CODE), .DEF_CODE(DEF_CODE)) u_dp (
    .clkIn   (clkIn),
    .rstN    (rstN),
    .defDiv8 (defDiv8),
    .strobe  (strobe),
    .wrapNext(wrapNext),
    .clkOut  (clkOut)
  );

endmodule

// File: tb/sysclk_prescaler_tb.sv
`timescale 1ns/1ps
module sysclk_prescaler_tb;

  logic       clkIn = 1'b0;
  logic       rstN = 1'b0;
  logic       defDiv8 = 1'b1;
  logic       wrEn = 1'b0;
  logic [3:0] wrCode = '0;
  logic       clkOut;
  logic       busy;

  sysclk_prescaler u_dut (
    .clkIn(clkIn), .rstN(rstN), .defDiv8(defDiv8), .wrEn(wrEn),
    .wrCode(wrCode), .clkOut(clkOut), .busy(busy)
  );

  always #2.5 clkIn = ~clkIn;

  int      errors = 0;
  int      checks = 0;
  int      expQ[$];
  int      curCode = 3;
  int      drvCode = 3;
  int      transLeft = 0;
  longint  boundPs = 0;
  bit      measureEn = 0;
  bit      haveLast = 0;
  realtime lastT = 0.0;

  function automatic longint halfPs(int c);
    return 64'd2500 << c;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: every output phase is compared with the scoreboard's ratio.
  always @(clkOut) begin
    realtime t;
    longint  durPs;
    t = $realtime;
    #0.1;
    if (measureEn && haveLast) begin
      durPs = $rtoi((t - lastT) * 1000.0 + 0.5);
      if (transLeft > 0) begin
        chk(durPs >= boundPs, "R7 phase during change", durPs, boundPs);
        transLeft--;
      end else begin
        chk(durPs == halfPs(curCode), "R2 steady phase", durPs, halfPs(curCode));
      end
    end
    lastT = t;
    haveLast = measureEn;
  end

  // Scoreboard pop: the end of busy means the front code takes over.
  always @(negedge busy) begin
    if (measureEn) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R6 busy fell with nothing pending", 0, 1);
      end else begin
        int nxt;
        nxt = expQ.pop_front();
        boundPs = (halfPs(curCode) < halfPs(nxt)) ? halfPs(curCode) : halfPs(nxt);
        curCode = nxt;
        transLeft = 3;
      end
    end
  end

  task automatic doReset(bit def);
    realtime t0;
    longint  perPs;
    measureEn = 0;
    haveLast = 0;
    @(negedge clkIn);
    rstN = 1'b0;
    defDiv8 = def;
    repeat (3) @(negedge clkIn);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    if (def) chk(clkOut == 1'b0, "R1 clkOut in reset", clkOut, 0);
    expQ.delete();
    curCode = def ? 3 : 0;
    drvCode = curCode;
    transLeft = 0;
    rstN = 1'b1;
    measureEn = 1;
    @(posedge clkOut);
    t0 = $realtime;
    @(posedge clkOut);
    perPs = $rtoi(($realtime - t0) * 1000.0 + 0.5);
    chk(perPs == 2 * halfPs(curCode), "R1 period after reset", perPs, 2 * halfPs(curCode));
  endtask

  // Driver: one write; valid codes enter the scoreboard queue.
  task automatic writeCode(int c);
    bit wasBusy;
    @(negedge clkIn);
    wasBusy = busy;
    wrEn = 1'b1;
    wrCode = 4'(c);
    @(negedge clkIn);
    wrEn = 1'b0;
    if (c <= 8) begin
      if (wasBusy && expQ.size() > 0) expQ[expQ.size()-1] = c;  // R5
      else expQ.push_back(c);
      drvCode = c;
      chk(busy == 1'b1, "R4 busy after write", busy, 1);
    end else if (!wasBusy) begin
      chk(busy == 1'b0, "R3 reserved write raised busy", busy, 0);
    end
  endtask

  task automatic waitApplied(int c);
    int n = 0;
    while (busy && n < 400) begin
      @(negedge clkIn);
      n++;
    end
    chk(!busy && n <= 257, "R6 change latency", n, 256);
    repeat (2 * (1 << c) + 6) @(negedge clkIn);
  endtask

  task automatic applyCode(int c);
    writeCode(c);
    waitApplied(c);
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    doReset(1'b1);                       // R1: divide-by-8 default

    // R3: reserved code while idle, ratio must stay at 8
    writeCode(12);
    repeat (300) @(negedge clkIn);
    chk(busy == 1'b0, "R3 busy after reserved write", busy, 0);

    // R5: second write replaces the first, reserved write while busy ignored
    writeCode(6);
    repeat (2) @(negedge clkIn);
    writeCode(1);
    writeCode(13);
    waitApplied(1);
    drvCode = 1;

    // R2/R7: every ordered pair of legal codes
    for (int a = 0; a <= 8; a++) begin
      for (int b = 0; b <= 8; b++) begin
        if (drvCode != a) applyCode(a);
        applyCode(b);
      end
    end

    doReset(1'b0);                       // R1: divide-by-1 default
    applyCode(8);
    applyCode(0);

    measureEn = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule